// File: doc/BRIEF.md
# Pixel Hit-Time Store with Trigger Matching

This block is the digital memory of one pixel. It does not keep a full-latency history of every beam crossing. It keeps only the crossings in which the pixel fired. On each hit it writes the present value of a free-running crossing counter into one of a few storage slots. When a level-1 trigger arrives, each occupied slot compares its stamp with the trigger's crossing, which is the present count minus a fixed latency, using modulo arithmetic. Every slot that matches is marked as selected for readout.

Selected stamps leave the block through a valid/ready output stream. `out_valid_o` stays high and `out_time_o` stays unchanged until the reader accepts the entry by raising `out_ready_i` on a clock edge. Accepting an entry frees its slot. The hit input cannot be back-pressured. A hit that finds every slot occupied is lost, and a sticky flag records the loss. A slot that no trigger selected is freed as soon as its stamp is older than the latency, so slot space is only used by hits that a trigger could still claim.

The defaults are an 8-bit stamp, a latency of 120 crossings and 16 slots. A 24-slot build is obtained by changing `DEPTH`. The crossing counter at `bx_time_i` is expected to advance by one every clock.

Top module: `pixhit_store`

## Requirements
- R1: After reset, `out_valid_o` and `overflow_o` are 0 and every slot is empty.
- R2: A hit in a cycle that begins with at least one free slot stores that cycle's `bx_time_i` into the lowest-numbered free slot. A slot freed during the same cycle does not count as free until the next cycle.
- R3: A trigger in a cycle where `bx_time_i` is T selects every stored, unselected entry whose stamp equals (T − 120) mod 256. `out_valid_o` rises in the next cycle, with that stamp on `out_time_o`. If no entry matches, `out_valid_o` stays 0.
- R4: The trigger's target crossing wraps modulo 256. A trigger at count 64 matches a stamp of 200.
- R5: An entry that is not selected and whose age, (`bx_time_i` − stamp) mod 256, exceeds 120 is discarded at the end of that cycle. Its slot becomes free for later hits.
- R6: A hit that arrives while all slots are occupied is not stored. `overflow_o` is set from the next cycle and stays 1 until reset. Entries that were already stored are kept.
- R7: While `out_valid_o` is 1 and `out_ready_i` is 0, `out_valid_o` and `out_time_o` hold, and the selected entry is protected from aging out. A clock edge with both signals at 1 removes the presented entry.
- R8: When several entries are selected, they are presented one at a time. A presented entry is kept until it is accepted. After that, the lowest-numbered remaining selected slot is presented.
- R9: A hit and a trigger in the same cycle are both carried out. The new stamp cannot match that trigger, but later triggers can match it.
- R10: `out_ready_i` has no effect while `out_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one beam crossing per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | 1 | Pixel hit strobe |
| bx_time_i | input | TW (8) | Free-running crossing counter |
| trig_i | input | 1 | Level-1 trigger strobe |
| out_ready_i | input | 1 | Reader accepts the presented stamp |
| out_valid_o | output | 1 | A selected stamp is presented |
| out_time_o | output | TW (8) | Presented selected stamp |
| overflow_o | output | 1 | Sticky flag: a hit was lost to full storage |

## Verification
The hardest cases to reach from the ports are aging and the lost-hit path. Aging is only visible through slot reuse: the bench fills all sixteen slots on consecutive crossings and waits past the latency. It then shows that a further hit is stored without raising the overflow flag and is matched by a trigger 120 crossings later. A full store is reached with sixteen back-to-back hits. A trigger aimed exactly at the seventeenth (lost) hit must find nothing. Two pending selections are created with hits on adjacent crossings followed by triggers on adjacent crossings, while the reader holds ready low.

// File: rtl/pixhit_pkg.sv
`timescale 1ns/1ps
package pixhit_pkg;
  localparam int unsigned TS_W_DEF  = 8;
  localparam int unsigned LAT_DEF   = 120;
  localparam int unsigned DEPTH_DEF = 16;

  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_SEL  = 2'd2
  } slot_st_e;
endpackage

// File: rtl/pixhit_slot.sv
`timescale 1ns/1ps
// One stamp slot: holds a hit crossing, ages it, matches it on trigger.
module pixhit_slot
  import pixhit_pkg::*;
#(
  parameter int unsigned TW  = TS_W_DEF,
  parameter int unsigned LAT = LAT_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] now_i,
  input  logic          wr_i,
  input  logic          trig_i,
  input  logic          clr_i,
  output slot_st_e      st_o,
  output logic [TW-1:0] stamp_o
);
  localparam logic [TW-1:0] LAT_T = TW'(LAT);

  slot_st_e      st_q;
  logic [TW-1:0] stamp_q;
  logic [TW-1:0] age;
  logic [TW-1:0] target;
  logic          aged_out;
  logic          matched;

  always_comb begin
    age      = now_i - stamp_q;
    target   = now_i - LAT_T;
    aged_out = (st_q == SLOT_WAIT) && (age > LAT_T);
    matched  = (st_q == SLOT_WAIT) && trig_i && (stamp_q == target);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SLOT_FREE;
      stamp_q <= '0;
    end else if (wr_i) begin
      st_q    <= SLOT_WAIT;
      stamp_q <= now_i;
    end else if (clr_i && st_q == SLOT_SEL) begin
      st_q <= SLOT_FREE;
    end else if (aged_out) begin
      st_q <= SLOT_FREE;
    end else if (matched) begin
      st_q <= SLOT_SEL;
    end
  end

  assign st_o    = st_q;
  assign stamp_o = stamp_q;
endmodule

// File: rtl/pixhit_prio.sv
`timescale 1ns/1ps
// Lowest-index-first one-hot picker.
module pixhit_prio #(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic found;

  always_comb begin
    gnt_o = '0;
    found = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      if (req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pixhit_store.sv
`timescale 1ns/1ps
// Per-pixel hit-time store with level-1 trigger matching.
module pixhit_store
  import pixhit_pkg::*;
#(
  parameter int unsigned DEPTH = DEPTH_DEF,
  parameter int unsigned TW    = TS_W_DEF,
  parameter int unsigned LAT   = LAT_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_i,
  input  logic [TW-1:0] bx_time_i,
  input  logic          trig_i,
  input  logic          out_ready_i,
  output logic          out_valid_o,
  output logic [TW-1:0] out_time_o,
  output logic          overflow_o
);
  localparam int unsigned FLAT_W = DEPTH * TW;

  slot_st_e          st    [DEPTH];
  logic [TW-1:0]     stamp [DEPTH];
  logic [DEPTH-1:0]  vld;
  logic [DEPTH-1:0]  sel;
  logic [DEPTH-1:0]  alloc;
  logic [DEPTH-1:0]  wr_vec;
  logic [DEPTH-1:0]  first_sel;
  logic [DEPTH-1:0]  pick;
  logic [DEPTH-1:0]  lock_q;
  logic [DEPTH-1:0]  clr_vec;
  logic [FLAT_W-1:0] stamp_flat;
  logic              full;
  logic              accept;
  logic              ovf_q;

  // storage slots
  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_slot
    pixhit_slot #(.TW(TW), .LAT(LAT)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .now_i   (bx_time_i),
      .wr_i    (wr_vec[g]),
      .trig_i  (trig_i),
      .clr_i   (clr_vec[g]),
      .st_o    (st[g]),
      .stamp_o (stamp[g])
    );
    assign vld[g] = (st[g] != SLOT_FREE);
    assign sel[g] = (st[g] == SLOT_SEL);
    assign stamp_flat[g*TW +: TW] = stamp[g];
  end

  // free-slot allocation
  pixhit_prio #(.N(DEPTH)) u_alloc (
    .req_i (~vld),
    .gnt_o (alloc)
  );

  // readout selection
  pixhit_prio #(.N(DEPTH)) u_pick (
    .req_i (sel),
    .gnt_o (first_sel)
  );

  assign full        = &vld;
  assign wr_vec      = alloc & {DEPTH{hit_i & ~full}};
  assign pick        = (|lock_q) ? lock_q : first_sel;
  assign out_valid_o = |sel;
  assign accept      = out_valid_o & out_ready_i;
  assign clr_vec     = pick & {DEPTH{accept}};

  always_comb begin
    out_time_o = '0;
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (pick[i]) out_time_o = out_time_o | stamp_flat[i*TW +: TW];
    end
  end

  // keep the presented entry until it is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= '0;
    else        lock_q <= (out_valid_o && !out_ready_i) ? pick : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ovf_q <= 1'b0;
    else if (hit_i && full)  ovf_q <= 1'b1;
  end

  assign overflow_o = ovf_q;
endmodule

// File: rtl/pixhit_store_chk.sv
`timescale 1ns/1ps
module pixhit_store_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TW    = 8,
  parameter int unsigned LAT   = 120
) (
  input logic                clk,
  input logic                rst_n,
  input logic                hit_i,
  input logic [TW-1:0]       bx_time_i,
  input logic                trig_i,
  input logic                out_ready_i,
  input logic                out_valid_o,
  input logic [TW-1:0]       out_time_o,
  input logic                overflow_o,
  input logic [DEPTH-1:0]    vld,
  input logic [DEPTH-1:0]    sel,
  input logic [DEPTH*TW-1:0] stamp_flat
);
  localparam logic [TW-1:0] LAT_T  = TW'(LAT);
  localparam logic [TW-1:0] LAT_T1 = TW'(LAT + 1);

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> out_valid_o); // R7
  AST_HOLD_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> $stable(out_time_o)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o); // R6
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i && ($countones(vld) == DEPTH) |=> overflow_o); // R6
  AST_RISE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid_o) |-> $past(trig_i) && (out_time_o == TW'($past(bx_time_i) - LAT_T))); // R3

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_age
    AST_NO_STALE: assert property (@(posedge clk) disable iff (!rst_n)
      vld[g] && !sel[g] |-> TW'(bx_time_i - stamp_flat[g*TW +: TW]) <= LAT_T1); // R5
  end
endmodule

bind pixhit_store pixhit_store_chk #(.DEPTH(DEPTH), .TW(TW), .LAT(LAT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hit_i       (hit_i),
  .bx_time_i   (bx_time_i),
  .trig_i      (trig_i),
  .out_ready_i (out_ready_i),
  .out_valid_o (out_valid_o),
  .out_time_o  (out_time_o),
  .overflow_o  (overflow_o),
  .vld         (vld),
  .sel         (sel),
  .stamp_flat  (stamp_flat)
);

// File: tb/tb_pixhit_store.sv
`timescale 1ns/1ps
module tb_pixhit_store;
  localparam int DEPTH = 16;
  localparam int LAT   = 120;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hit = 1'b0;
  logic       trig = 1'b0;
  logic       rdy = 1'b0;
  logic [7:0] bx_time = '0;
  logic       out_valid;
  logic [7:0] out_time;
  logic       overflow;

  int bx = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  pixhit_store dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit_i       (hit),
    .bx_time_i   (bx_time),
    .trig_i      (trig),
    .out_ready_i (rdy),
    .out_valid_o (out_valid),
    .out_time_o  (out_time),
    .overflow_o  (overflow)
  );

  always #10 clk = ~clk;

  typedef struct packed {
    logic [7:0] gap;
    logic       h;
    logic       t;
    logic       r;
    logic       ev;
    logic [7:0] et;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 19;
  // gap idle crossings, then one stimulus crossing; expected outputs after its edge
  localparam vec_t TBL [NV] = '{
    '{8'd0,   1'b1, 1'b0, 1'b0, 1'b0, 8'd0,   4'd2},  // bx0   hit           R2
    '{8'd4,   1'b1, 1'b0, 1'b1, 1'b0, 8'd0,   4'd10}, // bx5   hit, idle ack R10
    '{8'd114, 1'b1, 1'b1, 1'b0, 1'b1, 8'd0,   4'd3},  // bx120 trig+hit      R3 R9
    '{8'd2,   1'b0, 1'b0, 1'b0, 1'b1, 8'd0,   4'd7},  // bx123 held          R7
    '{8'd0,   1'b0, 1'b0, 1'b1, 1'b0, 8'd0,   4'd7},  // bx124 accept        R7
    '{8'd0,   1'b0, 1'b1, 1'b0, 1'b1, 8'd5,   4'd10}, // bx125 trig          R10
    '{8'd0,   1'b0, 1'b0, 1'b1, 1'b0, 8'd0,   4'd7},  // bx126 accept
    '{8'd0,   1'b0, 1'b1, 1'b1, 1'b0, 8'd0,   4'd3},  // bx127 trig miss     R3
    '{8'd72,  1'b1, 1'b0, 1'b0, 1'b0, 8'd0,   4'd2},  // bx200 hit
    '{8'd39,  1'b0, 1'b1, 1'b0, 1'b1, 8'd120, 4'd9},  // bx240 same-cycle hit matched R9
    '{8'd0,   1'b0, 1'b0, 1'b1, 1'b0, 8'd0,   4'd7},  // bx241
    '{8'd78,  1'b0, 1'b1, 1'b0, 1'b1, 8'd200, 4'd4},  // bx320 wrap          R4
    '{8'd0,   1'b0, 1'b0, 1'b1, 1'b0, 8'd0,   4'd7},  // bx321
    '{8'd0,   1'b1, 1'b0, 1'b0, 1'b0, 8'd0,   4'd2},  // bx322 hit (66)
    '{8'd0,   1'b1, 1'b0, 1'b0, 1'b0, 8'd0,   4'd2},  // bx323 hit (67)
    '{8'd118, 1'b0, 1'b1, 1'b0, 1'b1, 8'd66,  4'd3},  // bx442 trig
    '{8'd0,   1'b0, 1'b1, 1'b0, 1'b1, 8'd66,  4'd8},  // bx443 second select R8
    '{8'd0,   1'b0, 1'b0, 1'b1, 1'b1, 8'd67,  4'd8},  // bx444 next presented R8
    '{8'd0,   1'b0, 1'b0, 1'b1, 1'b0, 8'd0,   4'd8}   // bx445 drained
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input logic h, input logic t, input logic r);
    @(negedge clk);
    hit = h; trig = t; rdy = r; bx_time = bx[7:0];
    @(posedge clk);
    #2;
    bx++;
  endtask

  task automatic idle_to(input int target);
    while (bx < target) tick(1'b0, 1'b0, 1'b0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hang expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    int h0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 overflow", int'(overflow), 0);
    @(negedge clk);
    rst_n = 1'b1;
    bx = 0;

    // vector table
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d row%0d", TBL[i].req, i);
      repeat (int'(TBL[i].gap)) tick(1'b0, 1'b0, 1'b0);
      tick(TBL[i].h, TBL[i].t, TBL[i].r);
      chk({tag, " valid"}, int'(out_valid), int'(TBL[i].ev));
      if (TBL[i].ev) chk({tag, " time"}, int'(out_time), int'(TBL[i].et));
      chk({tag, " overflow"}, int'(overflow), 0);
    end

    // R5: fill every slot, let them age out, then a new hit must find space
    for (int k = 0; k < DEPTH; k++) tick(1'b1, 1'b0, 1'b0);
    chk("R5 full without loss", int'(overflow), 0);
    idle_to(bx + LAT + 5);
    h0 = bx;
    tick(1'b1, 1'b0, 1'b0);
    chk("R5 freed slot reused", int'(overflow), 0);
    idle_to(h0 + LAT);
    tick(1'b0, 1'b1, 1'b0);
    chk("R5 reused match valid", int'(out_valid), 1);
    chk("R5 reused match time", int'(out_time), h0 % 256);
    tick(1'b0, 1'b0, 1'b1);
    chk("R5 drained", int'(out_valid), 0);

    // R6: overflow on hit into full store
    h0 = bx;
    for (int k = 0; k < DEPTH; k++) tick(1'b1, 1'b0, 1'b0);
    chk("R6 no overflow at exactly full", int'(overflow), 0);
    tick(1'b1, 1'b0, 1'b0);
    chk("R6 overflow set", int'(overflow), 1);
    idle_to(h0 + LAT);
    tick(1'b0, 1'b1, 1'b0);
    chk("R6 oldest kept valid", int'(out_valid), 1);
    chk("R6 oldest kept time", int'(out_time), h0 % 256);
    tick(1'b0, 1'b0, 1'b1);
    idle_to(h0 + DEPTH + LAT);
    tick(1'b0, 1'b1, 1'b0);
    chk("R6 lost hit not matched", int'(out_valid), 0);
    chk("R6 overflow sticky", int'(overflow), 1);

    // R1: reset during operation
    @(negedge clk);
    rst_n = 1'b0;
    tick(1'b0, 1'b0, 1'b0);
    chk("R1 reset clears overflow", int'(overflow), 0);
    chk("R1 reset clears valid", int'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    tick(1'b0, 1'b1, 1'b0);
    chk("R1 empty after reset", int'(out_valid), 0);

    done = 1;
    summary();
    $finish;
  end
endmodule